// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO

This block moves 18-bit words from a write-clock domain to an unrelated (or identical) read-clock domain through 64 entries of storage plus one output register. The write side offers a word with a pair of enables, one active-high and one active-low. It sees a ready flag that drops when no room is left. The read side sees an output-ready flag and the word at the head of the queue. It consumes that word with an active-low read enable, gated by two active-low output enables.

The head of the queue falls through on its own. Once a word lands in empty storage it is moved into the output register without any read request. The output-ready flag rises together with it. The data pins themselves are not modelled as tri-state. Instead a separate flag shows whether the outputs would be driven.

Reset is active-low and asynchronous to both clocks. It is meant to be held across at least four rising edges of each clock.

Top module: `xclk_fwft_fifo`

## Requirements
- R1: A word is stored on a rising `wclk` edge only when `wr_en` is 1, `wr_en_n` is 0 and `in_ready` is 1; with any other enable combination nothing enters the queue.
- R2: The head word is consumed on a rising `rclk` edge only when `rd_en_n`, `oe_a_n` and `oe_b_n` are all 0 and `out_ready` is 1; the next stored word then appears on `rdata` at that same edge.
- R3: The first word written into an empty FIFO reaches `rdata`, with `out_ready` rising, on the third `rclk` rising edge after the write edge (clocks coincident), whatever the levels of `rd_en_n`, `oe_a_n` and `oe_b_n`.
- R4: While `out_ready` is 0, `rdata` keeps the last word that was read.
- R5: `in_ready` is 0 during reset and rises on the second `wclk` rising edge after `rst_n` returns to 1.
- R6: Driving `rst_n` to 0 at any time forces `in_ready` and `out_ready` to 0 without waiting for a clock edge and discards all stored words.
- R7: With no reads, exactly 65 words are accepted (64 in storage plus the output register); `in_ready` is then 0, and the 65 words drain in the order written.
- R8: If `oe_a_n` or `oe_b_n` is 1, no word is consumed and `rdata_drv` is 0; `rdata_drv` is 1 only when both are 0.
- R9: With unrelated write and read clocks the words arrive complete and in order; each domain's Gray pointer changes by at most one bit per clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wclk | input | 1 | Free-running write clock |
| wr_en | input | 1 | Active-high write enable |
| wr_en_n | input | 1 | Active-low write enable |
| wdata | input | 18 | Word to store |
| in_ready | output | 1 | Room available; write-clock synchronous |
| rclk | input | 1 | Free-running read clock |
| rd_en_n | input | 1 | Active-low read enable |
| oe_a_n | input | 1 | First active-low output enable |
| oe_b_n | input | 1 | Second active-low output enable |
| rdata | output | 18 | Head word held in the output register |
| rdata_drv | output | 1 | 1 when both output enables are low |
| out_ready | output | 1 | Valid head word present; read-clock synchronous |

## Verification
The bench counts clock edges from the first write to the moment `out_ready` rises. A design that skips a synchronizer flop, or that waits for a read request before filling the output register, shows the word one edge early or not at all. The bench fills the queue until `in_ready` drops and expects exactly 65 accepted words. An off-by-one in the Gray full compare, or an output register that is not counted as a slot, shows up as 64 or 66 words, or as a word overwritten before it is read. Each enable and output-enable combination is tried against a held head word, so an incomplete read qualifier would show up as a skipped word. The final checks stream words across unrelated clocks and then reset the FIFO in the middle of an operation. They catch reordered data and flags that wait for a clock before clearing.

// File: rtl/xff_pkg.sv
`timescale 1ns/1ps
package xff_pkg;
  localparam int unsigned XFF_DATA_W = 18;
  localparam int unsigned XFF_ADDR_W = 6;
  localparam int unsigned XFF_SYNC_N = 2;
  localparam int unsigned XFF_WAKE_N = 2;
endpackage

// File: rtl/xff_sync.sv
`timescale 1ns/1ps
module xff_sync #(
  parameter int W = 7,
  parameter int N = xff_pkg::XFF_SYNC_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < N; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[N-1];
endmodule

// File: rtl/xff_ram.sv
`timescale 1ns/1ps
module xff_ram #(
  parameter int AW = xff_pkg::XFF_ADDR_W,
  parameter int DW = xff_pkg::XFF_DATA_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/xff_wr_side.sv
`timescale 1ns/1ps
module xff_wr_side #(
  parameter int AW = xff_pkg::XFF_ADDR_W,
  parameter int WAKE_N = xff_pkg::XFF_WAKE_N,
  localparam int PW = AW + 1
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_en_n,
  input  logic [PW-1:0] rq_gray,
  output logic          in_ready,
  output logic          wr_fire,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray
);
  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // full: write pointer is one lap ahead of the synchronized read pointer
  function automatic logic lap_ahead(input logic [PW-1:0] wg, input logic [PW-1:0] rg);
    return wg == {~rg[PW-1:PW-2], rg[PW-3:0]};
  endfunction

  logic [WAKE_N-1:0] wake;
  logic [PW-1:0]     wbin;
  logic [PW-1:0]     wbin_nxt;
  logic              full;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) wake <= '0;
    else        wake <= {wake[WAKE_N-2:0], 1'b1};
  end

  assign full     = lap_ahead(wgray, rq_gray);
  assign in_ready = wake[WAKE_N-1] & ~full;
  assign wr_fire  = wr_en & ~wr_en_n & in_ready;
  assign wbin_nxt = wbin + 1'b1;
  assign waddr    = wbin[AW-1:0];

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_fire) begin
      wbin  <= wbin_nxt;
      wgray <= to_gray(wbin_nxt);
    end
  end
endmodule

// File: rtl/xff_rd_side.sv
`timescale 1ns/1ps
module xff_rd_side #(
  parameter int AW = xff_pkg::XFF_ADDR_W,
  parameter int DW = xff_pkg::XFF_DATA_W,
  localparam int PW = AW + 1
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          rd_en_n,
  input  logic          oe_a_n,
  input  logic          oe_b_n,
  input  logic [PW-1:0] wq_gray,
  input  logic [DW-1:0] mem_q,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic [DW-1:0] head,
  output logic          head_vld
);
  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [PW-1:0] rbin;
  logic [PW-1:0] rbin_nxt;
  logic          store_empty;
  logic          take;
  logic          refill;

  assign store_empty = (rgray == wq_gray);
  assign take        = head_vld & ~rd_en_n & ~oe_a_n & ~oe_b_n;
  assign refill      = ~store_empty & (~head_vld | take);
  assign rbin_nxt    = rbin + 1'b1;
  assign raddr       = rbin[AW-1:0];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      head     <= '0;
      head_vld <= 1'b0;
    end else if (refill) begin
      rbin     <= rbin_nxt;
      rgray    <= to_gray(rbin_nxt);
      head     <= mem_q;
      head_vld <= 1'b1;
    end else if (take) begin
      head_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/xclk_fwft_fifo.sv
`timescale 1ns/1ps
module xclk_fwft_fifo #(
  parameter int DATA_W = xff_pkg::XFF_DATA_W,
  parameter int ADDR_W = xff_pkg::XFF_ADDR_W,
  parameter int SYNC_N = xff_pkg::XFF_SYNC_N,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              rst_n,
  input  logic              wclk,
  input  logic              wr_en,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] wdata,
  output logic              in_ready,
  input  logic              rclk,
  input  logic              rd_en_n,
  input  logic              oe_a_n,
  input  logic              oe_b_n,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_drv,
  output logic              out_ready
);
  logic [PTR_W-1:0]  wgray;
  logic [PTR_W-1:0]  rgray;
  logic [PTR_W-1:0]  wq_gray;
  logic [PTR_W-1:0]  rq_gray;
  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W-1:0] raddr;
  logic [DATA_W-1:0] mem_q;
  logic              wr_fire;

  xff_wr_side #(.AW(ADDR_W)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .wr_en(wr_en), .wr_en_n(wr_en_n),
    .rq_gray(rq_gray), .in_ready(in_ready), .wr_fire(wr_fire),
    .waddr(waddr), .wgray(wgray)
  );

  xff_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
    .wclk(wclk), .we(wr_fire), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(mem_q)
  );

  xff_sync #(.W(PTR_W), .N(SYNC_N)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wq_gray)
  );

  xff_sync #(.W(PTR_W), .N(SYNC_N)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rq_gray)
  );

  xff_rd_side #(.AW(ADDR_W), .DW(DATA_W)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .rd_en_n(rd_en_n), .oe_a_n(oe_a_n),
    .oe_b_n(oe_b_n), .wq_gray(wq_gray), .mem_q(mem_q), .raddr(raddr),
    .rgray(rgray), .head(rdata), .head_vld(out_ready)
  );

  assign rdata_drv = ~oe_a_n & ~oe_b_n;
endmodule

// File: rtl/xff_checker.sv
`timescale 1ns/1ps
module xff_checker #(
  parameter int DW = 18,
  parameter int PW = 7
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_ready,
  input logic          oe_a_n,
  input logic          oe_b_n,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray,
  input logic [DW-1:0] rdata
);
  // R1: a blocked write side must not advance its pointer
  p_blocked_write_r1: assert property (@(posedge wclk) disable iff (!rst_n)
    !in_ready |=> $stable(wgray));

  // R4: an empty output register keeps its word until a refill
  p_hold_idle_r4: assert property (@(posedge rclk) disable iff (!rst_n)
    !out_ready |=> (out_ready || $stable(rdata)));

  // R8: any output enable high keeps the head word in place
  p_oe_blocks_r8: assert property (@(posedge rclk) disable iff (!rst_n)
    (out_ready && (oe_a_n || oe_b_n)) |=> (out_ready && $stable(rdata)));

  // R9: pointers cross domains changing at most one bit per edge
  p_wgray_step_r9: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  p_rgray_step_r9: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

bind xclk_fwft_fifo xff_checker #(.DW(DATA_W), .PW(ADDR_W + 1)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .in_ready(in_ready),
  .out_ready(out_ready), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
  .wgray(wgray), .rgray(rgray), .rdata(rdata)
);

// File: tb/sim_xclk_fwft_fifo.sv
`timescale 1ns/1ps
module sim_xclk_fwft_fifo;
  logic        rst_n = 1'b0;
  logic        wclk = 1'b0;
  logic        rclk = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_en_n = 1'b1;
  logic [17:0] wdata = '0;
  logic        rd_en_n = 1'b1;
  logic        oe_a_n = 1'b1;
  logic        oe_b_n = 1'b1;
  logic        in_ready;
  logic [17:0] rdata;
  logic        rdata_drv;
  logic        out_ready;
  real         rhalf = 5.0;
  int          nchk = 0;
  int          nfail = 0;

  always #5 wclk = ~wclk;
  always #(rhalf) rclk = ~rclk;

  xclk_fwft_fifo u0 (
    .rst_n(rst_n), .wclk(wclk), .wr_en(wr_en), .wr_en_n(wr_en_n),
    .wdata(wdata), .in_ready(in_ready), .rclk(rclk), .rd_en_n(rd_en_n),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .rdata(rdata),
    .rdata_drv(rdata_drv), .out_ready(out_ready)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge wclk);
      #1;
    end
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [17:0] fill_word(input int i);
    return 18'((i * 2731 + 17) & 32'h3FFFF);
  endfunction

  function automatic logic [17:0] strm_word(input int i);
    return 18'((i * 977 + 32'h1234) & 32'h3FFFF);
  endfunction

  initial begin
    #1900000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    int acc;
    int got;
    int wn;
    int rn;
    // reset held over six edges of both clocks
    #1;
    tick(5);
    chk("R6", "in_ready in reset", 32'(in_ready), 0);
    chk("R6", "out_ready in reset", 32'(out_ready), 0);
    tick(1);
    rst_n = 1'b1;
    chk("R5", "in_ready right after release", 32'(in_ready), 0);
    tick(1);
    chk("R5", "in_ready after 1st edge", 32'(in_ready), 0);
    tick(1);
    chk("R5", "in_ready after 2nd edge", 32'(in_ready), 1);
    chk("R6", "out_ready empty", 32'(out_ready), 0);

    // R3: fall-through with all read enables high
    wr_en = 1'b1; wr_en_n = 1'b0; wdata = 18'h2A5C3;
    tick(1);
    wr_en = 1'b0; wr_en_n = 1'b1;
    chk("R3", "out_ready after write edge", 32'(out_ready), 0);
    tick(1);
    chk("R3", "out_ready edge 1", 32'(out_ready), 0);
    tick(1);
    chk("R3", "out_ready edge 2", 32'(out_ready), 0);
    tick(1);
    chk("R3", "out_ready edge 3", 32'(out_ready), 1);
    chk("R3", "rdata edge 3", 32'(rdata), 32'h2A5C3);
    chk("R8", "rdata_drv with oe high", 32'(rdata_drv), 0);

    wr_en = 1'b1; wr_en_n = 1'b0; wdata = 18'h0F00D;
    tick(1);
    wr_en = 1'b0; wr_en_n = 1'b1;
    tick(3);
    chk("R2", "head held without read", 32'(rdata), 32'h2A5C3);
    rd_en_n = 1'b0; oe_a_n = 1'b1; oe_b_n = 1'b0;
    tick(2);
    chk("R8", "oe_a_n high blocks read", 32'(rdata), 32'h2A5C3);
    chk("R8", "out_ready kept", 32'(out_ready), 1);
    chk("R8", "rdata_drv oe_a high", 32'(rdata_drv), 0);
    oe_a_n = 1'b0; oe_b_n = 1'b1;
    tick(1);
    chk("R8", "oe_b_n high blocks read", 32'(rdata), 32'h2A5C3);
    oe_b_n = 1'b0; rd_en_n = 1'b1;
    tick(1);
    chk("R2", "rd_en_n high blocks read", 32'(rdata), 32'h2A5C3);
    chk("R8", "rdata_drv both low", 32'(rdata_drv), 1);
    rd_en_n = 1'b0;
    tick(1);
    chk("R2", "next word after read", 32'(rdata), 32'h0F00D);
    chk("R2", "out_ready after read", 32'(out_ready), 1);
    tick(1);
    chk("R4", "out_ready after last read", 32'(out_ready), 0);
    chk("R4", "last word held", 32'(rdata), 32'h0F00D);
    rd_en_n = 1'b1;
    tick(3);
    chk("R4", "last word still held", 32'(rdata), 32'h0F00D);

    // R1: wrong enable combinations store nothing
    wdata = 18'h3FFFF;
    wr_en = 1'b1; wr_en_n = 1'b1;
    tick(2);
    wr_en = 1'b0; wr_en_n = 1'b0;
    tick(2);
    wr_en = 1'b0; wr_en_n = 1'b1;
    tick(5);
    chk("R1", "no word from bad enables", 32'(out_ready), 0);
    chk("R1", "rdata unchanged", 32'(rdata), 32'h0F00D);

    // R7: fill to capacity without reads
    acc = 0;
    for (int i = 0; i < 70; i++) begin
      wdata = fill_word(acc);
      wr_en = 1'b1; wr_en_n = 1'b0;
      if (in_ready) acc++;
      tick(1);
    end
    wr_en = 1'b0; wr_en_n = 1'b1;
    chk("R7", "words accepted", 32'(acc), 65);
    chk("R7", "in_ready when full", 32'(in_ready), 0);
    tick(4);
    chk("R7", "in_ready stays low", 32'(in_ready), 0);
    rd_en_n = 1'b0;
    got = 0;
    for (int i = 0; i < 200; i++) begin
      if (out_ready) begin
        chk("R7", "drain order", 32'(rdata), 32'(fill_word(got)));
        got++;
      end
      tick(1);
    end
    rd_en_n = 1'b1;
    chk("R7", "words drained", 32'(got), 65);
    chk("R7", "in_ready after drain", 32'(in_ready), 1);

    // R9: unrelated clocks
    rhalf = 7.0;
    wn = 0;
    rn = 0;
    fork
      begin
        for (int c = 0; c < 3000 && wn < 200; c++) begin
          wr_en = (c % 3) != 2;
          wr_en_n = 1'b0;
          wdata = strm_word(wn);
          if (wr_en && in_ready) wn++;
          @(posedge wclk);
          #1;
        end
        wr_en = 1'b0; wr_en_n = 1'b1;
      end
      begin
        @(posedge rclk);
        #1;
        for (int c = 0; c < 6000 && rn < 200; c++) begin
          rd_en_n = (c % 4) == 3;
          if (!rd_en_n && out_ready) begin
            chk("R9", "stream word", 32'(rdata), 32'(strm_word(rn)));
            rn++;
          end
          @(posedge rclk);
          #1;
        end
        rd_en_n = 1'b1;
      end
    join
    chk("R9", "words written", 32'(wn), 200);
    chk("R9", "words read", 32'(rn), 200);

    // R6: asynchronous reset with words stored
    for (int i = 0; i < 3; i++) begin
      wr_en = 1'b1; wr_en_n = 1'b0; wdata = 18'(i + 5);
      tick(1);
    end
    wr_en = 1'b0; wr_en_n = 1'b1;
    tick(10);
    chk("R6", "out_ready before reset", 32'(out_ready), 1);
    #3;
    rst_n = 1'b0;
    #1;
    chk("R6", "in_ready cleared async", 32'(in_ready), 0);
    chk("R6", "out_ready cleared async", 32'(out_ready), 0);
    tick(6);
    rst_n = 1'b1;
    tick(2);
    chk("R5", "in_ready after second reset", 32'(in_ready), 1);
    tick(6);
    chk("R6", "stored words discarded", 32'(out_ready), 0);

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule